// File: doc/BRIEF.md
# Dual-Window Instruction Prefetch Queue

This block decouples an instruction fetch front end from an execution pipeline. The fetch side delivers one decoded instruction per cycle. Each instruction is a 16-bit opword, two 16-bit extension words that may be unused, and an early-decode vector. The block stores up to eight of these in arrival order. The consumer sees a window of two instructions. The first is the head instruction in full, with its opword, both extension words and its decode vector. The second is the opword and decode vector of the instruction after it, which lets the consumer issue two instructions in one cycle.

Each cycle the consumer reports how many instructions it took: none, one or two. When the queue is empty, an incoming instruction appears on the head outputs in the same cycle it arrives. If the consumer takes it in that cycle, it is never written into storage, so the buffer adds no latency while the consumer keeps up. A flush input drops all stored instructions when the flow of control changes.

Top module: `fetch_window_buf`

## Requirements
- R1: In the first cycle after reset, `in_ready_o` is high and both `hd_valid_o` and `nx_valid_o` are low.
- R2: While the queue is empty, `hd_valid_o` equals `in_valid_i` (when `flush_i` is low), and the head outputs show the incoming instruction in the same cycle. If `take_i` is 1 in that cycle, the instruction is consumed and is not stored.
- R3: Accepted instructions that are not consumed through the bypass appear at the head in arrival order. All four fields (opword, extension 1, extension 2, decode vector) are preserved.
- R4: `in_ready_o` is high while fewer than 8 instructions are stored and low when 8 are stored. An instruction offered while `in_ready_o` is low is discarded and never appears at the outputs.
- R5: `nx_valid_o` is high exactly when at least two instructions are stored. `nx_op_o` and `nx_dec_o` then show the instruction directly behind the head.
- R6: `take_i` encodes 2'd0 = take none, 2'd1 = take the head, 2'd2 = take head and second. The head advances by that amount. The value 2'd2 is used only while `nx_valid_o` is high.
- R7: When `flush_i` is high at a clock edge, afterwards no instructions are stored, `in_ready_o` is high and both valids are low until new input arrives. An instruction offered in the flush cycle and a take in the flush cycle are both ignored.
- R8: A write and a take in the same cycle both happen. When the queue is full, a take frees space and `in_ready_o` rises in the following cycle; `in_ready_o` does not depend combinationally on `take_i`.
- R9: A stored head instruction that is not taken and not flushed stays on the head outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop all stored instructions (change of flow) |
| in_valid_i | input | 1 | Incoming instruction present |
| in_ready_o | output | 1 | Queue has space for one instruction |
| in_op_i | input | 16 | Incoming opword |
| in_ext1_i | input | 16 | Incoming first extension word |
| in_ext2_i | input | 16 | Incoming second extension word |
| in_dec_i | input | DEC_W (12) | Incoming early-decode vector |
| take_i | input | 2 | Number of instructions consumed this cycle (0, 1, 2) |
| hd_valid_o | output | 1 | Head instruction present |
| hd_op_o | output | 16 | Head opword |
| hd_ext1_o | output | 16 | Head first extension word |
| hd_ext2_o | output | 16 | Head second extension word |
| hd_dec_o | output | DEC_W (12) | Head decode vector |
| nx_valid_o | output | 1 | Second instruction present |
| nx_op_o | output | 16 | Second opword |
| nx_dec_o | output | DEC_W (12) | Second decode vector |

## Verification
The hardest state to reach from the ports is a full queue in which the consumer takes and the producer pushes in the same cycle. In that state `in_ready_o` must stay low for that edge and rise only after it, and the offered instruction must vanish rather than overwrite storage. The stimulus fills the queue with the consumer idle and offers one extra instruction. It then streams takes of one alongside new input, and drains with takes of two. A long pseudo-random phase then mixes bypass, dual takes and rare flushes. A reference queue in the bench predicts every head and second-window value throughout.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int WORD_W = 16;
  localparam int EXT_N  = 2;

  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_ONE  = 2'd1,
    TAKE_TWO  = 2'd2,
    TAKE_RSVD = 2'd3
  } take_e;
endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          in_valid_i,
  input  take_e         take_i,
  output logic [CW-1:0] count_o,
  output logic          push_o,
  output logic [1:0]    pop_n_o,
  output logic          bypass_o,
  output logic          ready_o,
  output logic          hd_stored_o,
  output logic          nx_stored_o
);
  logic [CW-1:0] count_q;

  // How many stored entries leave the head for a given take request.
  function automatic logic [1:0] pop_amount(input logic [CW-1:0] cnt, input take_e tk);
    if (tk == TAKE_TWO && cnt > CW'(1)) return 2'd2;
    if ((tk == TAKE_ONE || tk == TAKE_TWO) && cnt != '0) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cnt,
                                               input logic add, input logic [1:0] sub);
    return cnt + CW'(add) - CW'(sub);
  endfunction

  assign ready_o     = (count_q != CW'(DEPTH));
  assign hd_stored_o = (count_q != '0);
  assign nx_stored_o = (count_q > CW'(1));
  assign bypass_o    = !flush_i && !hd_stored_o && in_valid_i &&
                       (take_i == TAKE_ONE || take_i == TAKE_TWO);
  assign push_o      = in_valid_i && ready_o && !flush_i && !bypass_o;
  assign pop_n_o     = flush_i ? 2'd0 : pop_amount(count_q, take_i);
  assign count_o     = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (flush_i) count_q <= '0;
    else              count_q <= next_count(count_q, push_o, pop_n_o);
  end
endmodule

// File: rtl/fwb_ring.sv
module fwb_ring #(
  parameter int DEPTH   = 8,
  parameter int FRONT_W = 28,
  parameter int BACK_W  = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               push_i,
  input  logic [FRONT_W-1:0] wr_front_i,
  input  logic [BACK_W-1:0]  wr_back_i,
  input  logic [1:0]         pop_n_i,
  output logic [FRONT_W-1:0] head_front_o,
  output logic [BACK_W-1:0]  head_back_o,
  output logic [FRONT_W-1:0] next_front_o
);
  // Opword plus decode vector lives apart from the extension words, since
  // only the former is needed for the second window slot.
  logic [FRONT_W-1:0] front_mem [DEPTH];
  logic [BACK_W-1:0]  back_mem  [DEPTH];
  logic [PW-1:0]      wr_ptr_q, rd_ptr_q;

  function automatic logic [PW-1:0] ptr_adv(input logic [PW-1:0] p, input logic [1:0] n);
    logic [PW:0] s;
    s = {1'b0, p} + (PW+1)'(n);
    if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_adv(wr_ptr_q, 2'd1);
      rd_ptr_q <= ptr_adv(rd_ptr_q, pop_n_i);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      front_mem[wr_ptr_q] <= wr_front_i;
      back_mem[wr_ptr_q]  <= wr_back_i;
    end
  end

  assign head_front_o = front_mem[rd_ptr_q];
  assign head_back_o  = back_mem[rd_ptr_q];
  assign next_front_o = front_mem[ptr_adv(rd_ptr_q, 2'd1)];
endmodule

// File: rtl/fwb_window.sv
module fwb_window #(
  parameter int FRONT_W = 28,
  parameter int BACK_W  = 32
) (
  input  logic               hd_stored_i,
  input  logic               nx_stored_i,
  input  logic               in_valid_i,
  input  logic               flush_i,
  input  logic [FRONT_W-1:0] in_front_i,
  input  logic [BACK_W-1:0]  in_back_i,
  input  logic [FRONT_W-1:0] head_front_i,
  input  logic [BACK_W-1:0]  head_back_i,
  input  logic [FRONT_W-1:0] next_front_i,
  output logic               hd_valid_o,
  output logic [FRONT_W-1:0] hd_front_o,
  output logic [BACK_W-1:0]  hd_back_o,
  output logic               nx_valid_o,
  output logic [FRONT_W-1:0] nx_front_o
);
  // Empty queue: the incoming instruction is shown directly at the head.
  assign hd_valid_o = hd_stored_i || (in_valid_i && !flush_i);
  assign hd_front_o = hd_stored_i ? head_front_i : in_front_i;
  assign hd_back_o  = hd_stored_i ? head_back_i  : in_back_i;
  assign nx_valid_o = nx_stored_i;
  assign nx_front_o = next_front_i;
endmodule

// File: rtl/fetch_window_buf.sv
module fetch_window_buf
  import fwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DEC_W = 12,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int FRONT_W = WORD_W + DEC_W,
  localparam int BACK_W  = WORD_W * EXT_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_op_i,
  input  logic [WORD_W-1:0] in_ext1_i,
  input  logic [WORD_W-1:0] in_ext2_i,
  input  logic [DEC_W-1:0]  in_dec_i,
  input  logic [1:0]        take_i,
  output logic              hd_valid_o,
  output logic [WORD_W-1:0] hd_op_o,
  output logic [WORD_W-1:0] hd_ext1_o,
  output logic [WORD_W-1:0] hd_ext2_o,
  output logic [DEC_W-1:0]  hd_dec_o,
  output logic              nx_valid_o,
  output logic [WORD_W-1:0] nx_op_o,
  output logic [DEC_W-1:0]  nx_dec_o
);
  // Named internal events, observed by the bound checker.
  logic [CW-1:0] count_w;
  logic          push_w;
  logic [1:0]    pop_w;
  logic          bypass_w;
  logic          hd_stored_w, nx_stored_w;

  take_e              take_w;
  logic [FRONT_W-1:0] in_front_w, head_front_w, next_front_w, hd_front_w, nx_front_w;
  logic [BACK_W-1:0]  in_back_w, head_back_w, hd_back_w;

  assign take_w     = take_e'(take_i);
  assign in_front_w = {in_op_i, in_dec_i};
  assign in_back_w  = {in_ext1_i, in_ext2_i};

  fwb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .in_valid_i(in_valid_i),
    .take_i(take_w), .count_o(count_w), .push_o(push_w), .pop_n_o(pop_w),
    .bypass_o(bypass_w), .ready_o(in_ready_o),
    .hd_stored_o(hd_stored_w), .nx_stored_o(nx_stored_w)
  );

  fwb_ring #(.DEPTH(DEPTH), .FRONT_W(FRONT_W), .BACK_W(BACK_W)) ring_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .push_i(push_w),
    .wr_front_i(in_front_w), .wr_back_i(in_back_w), .pop_n_i(pop_w),
    .head_front_o(head_front_w), .head_back_o(head_back_w),
    .next_front_o(next_front_w)
  );

  fwb_window #(.FRONT_W(FRONT_W), .BACK_W(BACK_W)) win_i (
    .hd_stored_i(hd_stored_w), .nx_stored_i(nx_stored_w),
    .in_valid_i(in_valid_i), .flush_i(flush_i),
    .in_front_i(in_front_w), .in_back_i(in_back_w),
    .head_front_i(head_front_w), .head_back_i(head_back_w),
    .next_front_i(next_front_w),
    .hd_valid_o(hd_valid_o), .hd_front_o(hd_front_w), .hd_back_o(hd_back_w),
    .nx_valid_o(nx_valid_o), .nx_front_o(nx_front_w)
  );

  assign hd_op_o   = hd_front_w[FRONT_W-1 -: WORD_W];
  assign hd_dec_o  = hd_front_w[DEC_W-1:0];
  assign hd_ext1_o = hd_back_w[BACK_W-1 -: WORD_W];
  assign hd_ext2_o = hd_back_w[WORD_W-1:0];
  assign nx_op_o   = nx_front_w[FRONT_W-1 -: WORD_W];
  assign nx_dec_o  = nx_front_w[DEC_W-1:0];
endmodule

// File: rtl/fwb_chk.sv
module fwb_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [1:0]    take_i,
  input logic          hd_valid_o,
  input logic [15:0]   hd_op_o,
  input logic          nx_valid_o,
  input logic [CW-1:0] count_w,
  input logic          push_w,
  input logic [1:0]    pop_w,
  input logic          bypass_w
);
  p_bypass_no_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_w |=> (count_w == '0));

  p_count_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |=> (count_w == CW'($past(count_w) + CW'($past(push_w)) - CW'($past(pop_w)))));

  p_full_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready_o && take_i == 2'd0 && !flush_i) |=> !in_ready_o);

  p_second_needs_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nx_valid_o |-> hd_valid_o);

  p_dual_take_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i == 2'd2 && !flush_i) |-> nx_valid_o);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count_w == '0 && !nx_valid_o && in_ready_o));

  p_take_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready_o && take_i != 2'd0 && !flush_i) |=> in_ready_o);

  p_head_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_w != '0 && take_i == 2'd0 && !flush_i) |=> (hd_valid_o && $stable(hd_op_o)));

  always_comb begin
    if (rst_n) begin
      a_valid_consistent_r5: assert (!(nx_valid_o && !hd_valid_o || (bypass_w && push_w)));
    end
  end
endmodule

bind fetch_window_buf fwb_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .take_i(take_i), .hd_valid_o(hd_valid_o),
  .hd_op_o(hd_op_o), .nx_valid_o(nx_valid_o), .count_w(count_w),
  .push_w(push_w), .pop_w(pop_w), .bypass_w(bypass_w)
);

// File: tb/fetch_window_buf_tb_top.sv
module fetch_window_buf_tb_top;
  localparam int DEPTH = 8;
  localparam int DEC_W = 12;
  typedef logic [48+DEC_W-1:0] item_t;  // {op, ext1, ext2, dec}

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0, in_valid_i = 1'b0, in_ready_o;
  logic [15:0] in_op_i = '0, in_ext1_i = '0, in_ext2_i = '0;
  logic [DEC_W-1:0] in_dec_i = '0;
  logic [1:0] take_i = 2'd0;
  logic hd_valid_o, nx_valid_o;
  logic [15:0] hd_op_o, hd_ext1_o, hd_ext2_o, nx_op_o;
  logic [DEC_W-1:0] hd_dec_o, nx_dec_o;

  always #5 clk = ~clk;

  fetch_window_buf #(.DEPTH(DEPTH), .DEC_W(DEC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_op_i(in_op_i), .in_ext1_i(in_ext1_i),
    .in_ext2_i(in_ext2_i), .in_dec_i(in_dec_i), .take_i(take_i),
    .hd_valid_o(hd_valid_o), .hd_op_o(hd_op_o), .hd_ext1_o(hd_ext1_o),
    .hd_ext2_o(hd_ext2_o), .hd_dec_o(hd_dec_o), .nx_valid_o(nx_valid_o),
    .nx_op_o(nx_op_o), .nx_dec_o(nx_dec_o)
  );

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  int seq = 0;
  bit done = 0;

  function automatic item_t mk(input int n);
    logic [15:0] op;
    op = 16'h8000 | 16'(n * 7);
    return {op, op ^ 16'h0F0F, {op[7:0], op[15:8]}, op[11:0] ^ 12'hA5C};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  // Driver and monitor for one cycle: drive at the falling edge, compare the
  // window against the reference queue, then retire/accept at the rising edge.
  task automatic step(input bit v, input item_t it, input logic [1:0] tk,
                      input bit fl, input string req);
    item_t act_hd;
    logic [15+DEC_W:0] act_nx, exp_nx;
    bit exp_hv, bypass, accepted;
    int sz, npop;
    item_t exp_hd;
    @(negedge clk);
    in_valid_i = v;
    {in_op_i, in_ext1_i, in_ext2_i, in_dec_i} = it;
    take_i = tk;
    flush_i = fl;
    #1;
    sz = exp_q.size();
    exp_hv = (sz > 0) || (v && !fl);
    exp_hd = (sz > 0) ? exp_q[0] : it;
    chk(hd_valid_o == exp_hv, req, "hd_valid", 64'(hd_valid_o), 64'(exp_hv));
    if (exp_hv) begin
      act_hd = {hd_op_o, hd_ext1_o, hd_ext2_o, hd_dec_o};
      chk(act_hd == exp_hd, req, "head", 64'(act_hd), 64'(exp_hd));
    end
    chk(nx_valid_o == (sz >= 2), req, "nx_valid", 64'(nx_valid_o), 64'(sz >= 2));
    if (sz >= 2) begin
      act_nx = {nx_op_o, nx_dec_o};
      exp_nx = {exp_q[1][48+DEC_W-1 -: 16], exp_q[1][DEC_W-1:0]};
      chk(act_nx == exp_nx, req, "second", 64'(act_nx), 64'(exp_nx));
    end
    chk(in_ready_o == (sz < DEPTH), req, "ready", 64'(in_ready_o), 64'(sz < DEPTH));
    @(posedge clk);
    if (fl) begin
      exp_q.delete();
    end else begin
      bypass = (sz == 0) && v && (tk != 2'd0);
      accepted = v && (sz < DEPTH) && !bypass;
      npop = (tk == 2'd2 && sz >= 2) ? 2 : ((tk != 2'd0 && sz >= 1) ? 1 : 0);
      for (int k = 0; k < npop; k++) void'(exp_q.pop_front());
      if (accepted) exp_q.push_back(it);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    bit rv;
    logic [1:0] rt;
    bit rf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(in_ready_o == 1'b1, "R1", "ready", 64'(in_ready_o), 64'd1);
    chk(hd_valid_o == 1'b0, "R1", "hd_valid", 64'(hd_valid_o), 64'd0);
    chk(nx_valid_o == 1'b0, "R1", "nx_valid", 64'(nx_valid_o), 64'd0);

    // R2: bypass on an empty queue, consumed in the same cycle
    for (int i = 0; i < 3; i++) begin step(1'b1, mk(seq), 2'd1, 1'b0, "R2"); seq++; end
    step(1'b0, '0, 2'd0, 1'b0, "R2");
    // R2: offered with no take -> written, then visible
    step(1'b1, mk(seq), 2'd0, 1'b0, "R2"); seq++;
    step(1'b0, '0, 2'd1, 1'b0, "R2");

    // R4: fill to eight, then offer one more while full
    for (int i = 0; i < 8; i++) begin step(1'b1, mk(seq), 2'd0, 1'b0, "R4"); seq++; end
    step(1'b1, mk(seq), 2'd0, 1'b0, "R4"); seq++;
    step(1'b0, '0, 2'd0, 1'b0, "R9");

    // R8: take while pushing at full and below
    for (int i = 0; i < 4; i++) begin step(1'b1, mk(seq), 2'd1, 1'b0, "R8"); seq++; end

    // R6/R5: drain with dual takes
    for (int k = 0; k < 10 && exp_q.size() >= 2; k++) step(1'b0, '0, 2'd2, 1'b0, "R6");
    if (exp_q.size() == 1) step(1'b0, '0, 2'd1, 1'b0, "R3");
    step(1'b0, '0, 2'd0, 1'b0, "R5");

    // R7: flush with concurrent write and take
    for (int i = 0; i < 5; i++) begin step(1'b1, mk(seq), 2'd0, 1'b0, "R5"); seq++; end
    step(1'b1, mk(seq), 2'd1, 1'b1, "R7"); seq++;
    step(1'b0, '0, 2'd0, 1'b0, "R7");
    step(1'b1, mk(seq), 2'd1, 1'b1, "R7"); seq++;
    step(1'b0, '0, 2'd0, 1'b0, "R7");

    // R3: pseudo-random mix of bypass, single and dual takes, rare flushes
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rv = lfsr[0] | lfsr[5];
      rf = (lfsr[15:10] == 6'd0);
      if (lfsr[3:2] == 2'd2 && exp_q.size() >= 2) rt = 2'd2;
      else if (lfsr[3:2] != 2'd0 && lfsr[1] && (exp_q.size() >= 1 || rv)) rt = 2'd1;
      else rt = 2'd0;
      step(rv, mk(seq), rt, rf, "R3");
      seq++;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule